// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This unit compares two IEEE-754 operands, either both single precision or both double precision, and turns the outcome into a mask word. The mask is all ones across the operand width when the selected predicate holds and all zeros when it does not. The predicate comes from a packed 6-bit function field. Inside that field, a 3-bit relation code picks a combination of less, equal and unordered. One bit makes the compare signaling. Another bit switches to a small group of negated predicates. The top bit marks the encoding as illegal.

An operation is offered with a one-cycle valid strobe. The format select, the function field and both 64-bit operand words are sampled in that cycle. A single-precision operand sits in the low 32 bits of its word, and its upper 32 bits are ignored. One cycle later a done strobe pulses. In that cycle the registered mask, the invalid-operation cause, a sticky invalid flag and an illegal-encoding flag are valid. An illegal encoding writes no result: the mask keeps its previous value. The sticky flag accumulates invalid-operation events until reset.

Top module: `fp_pred_cmp`

## Requirements
- R1: The function field splits into relation code = bits [2:0], signaling select = bit 3, negated-group select = bit 4, and reserved bit = bit 5. Signaling compares and quiet compares give the same mask.
- R2: In the positive group (bit 4 = 0), relation codes 0 to 7 are true when the pair is, in order: never; unordered; equal; unordered or equal; less; unordered or less; less or equal; less or equal or unordered.
- R3: In the negated group (bit 4 = 1), code 1 is true for ordered pairs (less, equal or greater). Code 2 is true for unordered or not-equal pairs. Code 3 is true for ordered, not-equal pairs.
- R4: When function bit 5 is 1, the operation is flagged illegal (out_illegal = 1), whatever the other bits are.
- R5: Negated-group codes 0, 4, 5, 6 and 7 are reserved and flag the operation illegal.
- R6: An illegal operation leaves out_mask unchanged, drives out_inv_cause to 0 and leaves out_inv_sticky unchanged. It still pulses out_done.
- R7: A true predicate gives out_mask = all ones over 64 bits for double precision (in_dbl = 1). For single precision (in_dbl = 0) it gives 0x00000000FFFFFFFF. A false predicate gives all zeros. For single precision, bits [63:32] of the operand words do not affect the result.
- R8: A NaN in either operand makes the pair unordered. +0 and -0 compare equal. All other values are ordered by their numeric value.
- R9: On a legal operation, out_inv_cause is set as follows. For a quiet compare it is 1 only if either operand is a signaling NaN (a NaN whose top fraction bit is 0). For a signaling compare it is 1 if either operand is any NaN.
- R10: out_inv_sticky is set whenever out_inv_cause is set. It then stays at 1 until reset.
- R11: The results appear in the cycle after in_valid, with out_done = 1 for exactly that cycle. Without in_valid, out_done is 0 and all other outputs hold their values.
- R12: A synchronous active-low reset clears out_done, out_mask, out_inv_cause, out_inv_sticky and out_illegal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_dbl | input | 1 | Format select: 1 = double, 0 = single |
| in_func | input | 6 | Packed predicate function field |
| in_opa | input | 64 | First operand word |
| in_opb | input | 64 | Second operand word |
| out_done | output | 1 | Result strobe, one cycle after in_valid |
| out_mask | output | 64 | All-ones or all-zeros predicate mask |
| out_inv_cause | output | 1 | Invalid operation raised by the last operation |
| out_inv_sticky | output | 1 | Accumulated invalid-operation flag |
| out_illegal | output | 1 | Last operation had an illegal encoding |

## Verification
Every path into the registers is exercised within a single operation, so a fault shows up in the out_done cycle of the operation that hits it:
- A wrong relation decode or a swapped ordering key shows as an inverted mask.
- A mis-decoded reserved code shows as a missing illegal flag, or as a mask that changes when it should hold.
- A mis-classified NaN shows as a wrong invalid cause.

The sticky flag is the only state that reaches past one operation. A sticky register that fails to hold shows as a dropped flag on the next legal operation that raises no exception.

// File: rtl/fpc_pkg.sv
// Package: shared types and field positions for the predicate compare unit.
// Assumes the function field layout described in the brief.
package fpc_pkg;

    // Position of each control bit inside the function field
    localparam int FN_W       = 6;
    localparam int FN_SIG_BIT = 3;
    localparam int FN_NEG_BIT = 4;
    localparam int FN_RSV_BIT = 5;

    // Classification of one operand
    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } fpc_class_t;

    // One-hot outcome of ordering two operands (also used as an accept set)
    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic un;
    } fpc_rel_t;

endpackage

// File: rtl/fpc_classify.sv
// Module: fpc_classify
// Classifies one IEEE-754 value of width W with EW exponent bits.
// Assumes the standard layout: sign at the top, then exponent, then fraction,
// with the top fraction bit set for quiet NaNs.
module fpc_classify #(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0]           val,
    output fpc_pkg::fpc_class_t    cls
);
    localparam int FW = W - 1 - EW;

    logic [EW-1:0] expo;
    logic [FW-1:0] frac;

    assign expo = val[W-2 -: EW];
    assign frac = val[FW-1:0];

    // Derive the class flags from the exponent and fraction fields
    always_comb begin
        cls.sign    = val[W-1];
        cls.is_zero = (expo == '0) && (frac == '0);
        cls.is_nan  = (expo == '1) && (frac != '0);
        cls.is_snan = (expo == '1) && (frac != '0) && !frac[FW-1];
    end

endmodule

// File: rtl/fpc_order.sv
// Module: fpc_order
// Orders two W-bit IEEE-754 values: exactly one of lt/eq/gt/un is set.
// Assumes both values use the same format. Ordered values are compared
// through an unsigned key in which negative numbers are bit-inverted and
// positive numbers have the top bit forced high. Signed zeros are caught
// before the key compare.
module fpc_order #(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0]         opa,
    input  logic [W-1:0]         opb,
    output fpc_pkg::fpc_rel_t    rel,
    output logic                 any_nan,
    output logic                 any_snan
);
    fpc_pkg::fpc_class_t cls_a;
    fpc_pkg::fpc_class_t cls_b;
    logic [W-1:0]        key_a;
    logic [W-1:0]        key_b;

    fpc_classify #(.W(W), .EW(EW)) u_cls_a (.val(opa), .cls(cls_a));
    fpc_classify #(.W(W), .EW(EW)) u_cls_b (.val(opb), .cls(cls_b));

    // Map each operand to a monotonic unsigned key
    always_comb begin
        key_a = cls_a.sign ? ~opa : {1'b1, opa[W-2:0]};
        key_b = cls_b.sign ? ~opb : {1'b1, opb[W-2:0]};
    end

    // Pick the single relation that holds for the pair
    always_comb begin
        rel      = '0;
        any_nan  = cls_a.is_nan  | cls_b.is_nan;
        any_snan = cls_a.is_snan | cls_b.is_snan;
        if (any_nan)
            rel.un = 1'b1;
        else if (cls_a.is_zero && cls_b.is_zero)
            rel.eq = 1'b1;
        else if (key_a < key_b)
            rel.lt = 1'b1;
        else if (key_a > key_b)
            rel.gt = 1'b1;
        else
            rel.eq = 1'b1;
    end

endmodule

// File: rtl/fpc_decode.sv
// Module: fpc_decode
// Turns the packed function field into the set of relations that make the
// predicate true, a signaling flag and an illegal-encoding flag.
// Assumes the positive-group code bits directly name unordered (bit 0),
// equal (bit 1) and less (bit 2).
module fpc_decode (
    input  logic [fpc_pkg::FN_W-1:0] func,
    output fpc_pkg::fpc_rel_t        accept,
    output logic                     signaling,
    output logic                     illegal
);
    import fpc_pkg::*;

    logic [2:0] code;
    logic       negated;

    assign code      = func[2:0];
    assign negated   = func[FN_NEG_BIT];
    assign signaling = func[FN_SIG_BIT];

    // Build the accept set and flag reserved encodings
    always_comb begin
        accept  = '0;
        illegal = func[FN_RSV_BIT];
        if (!negated) begin
            accept.un = code[0];
            accept.eq = code[1];
            accept.lt = code[2];
        end else begin
            unique case (code)
                3'd1: begin
                    accept.lt = 1'b1;
                    accept.gt = 1'b1;
                    accept.eq = 1'b1;
                end
                3'd2: begin
                    accept.lt = 1'b1;
                    accept.gt = 1'b1;
                    accept.un = 1'b1;
                end
                3'd3: begin
                    accept.lt = 1'b1;
                    accept.gt = 1'b1;
                end
                default: illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/fp_pred_cmp.sv
// Module: fp_pred_cmp (top)
// Registered floating-point predicate compare. Each operation is strobed by
// in_valid. One cycle later out_done pulses, together with an all-ones or
// all-zeros mask, the invalid cause, the sticky invalid flag and the illegal
// flag. Assumes single-precision operands sit in the low SW bits of each
// operand word. An illegal encoding leaves the mask register untouched.
module fp_pred_cmp #(
    parameter int DW  = 64,
    parameter int DEW = 11,
    parameter int SW  = 32,
    parameter int SEW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_dbl,
    input  logic [fpc_pkg::FN_W-1:0]  in_func,
    input  logic [DW-1:0]             in_opa,
    input  logic [DW-1:0]             in_opb,
    output logic                      out_done,
    output logic [DW-1:0]             out_mask,
    output logic                      out_inv_cause,
    output logic                      out_inv_sticky,
    output logic                      out_illegal
);
    import fpc_pkg::*;

    localparam int NFMT = 2;
    localparam int FMT_W  [NFMT] = '{SW, DW};
    localparam int FMT_EW [NFMT] = '{SEW, DEW};
    localparam logic [DW-1:0] SGL_ONES = {{(DW-SW){1'b0}}, {SW{1'b1}}};

    fpc_rel_t rel_f   [NFMT];
    logic     nan_f   [NFMT];
    logic     snan_f  [NFMT];

    // One ordering datapath per format
    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        fpc_order #(.W(FMT_W[g]), .EW(FMT_EW[g])) u_order (
            .opa      (in_opa[FMT_W[g]-1:0]),
            .opb      (in_opb[FMT_W[g]-1:0]),
            .rel      (rel_f[g]),
            .any_nan  (nan_f[g]),
            .any_snan (snan_f[g])
        );
    end

    fpc_rel_t accept;
    logic     signaling;
    logic     illegal;

    fpc_decode u_decode (
        .func      (in_func),
        .accept    (accept),
        .signaling (signaling),
        .illegal   (illegal)
    );

    fpc_rel_t      rel_sel;
    logic          nan_sel;
    logic          snan_sel;
    logic          pred;
    logic          invalid;
    logic [DW-1:0] mask_next;

    // Select the active format and evaluate predicate and exception
    always_comb begin
        rel_sel   = in_dbl ? rel_f[1]  : rel_f[0];
        nan_sel   = in_dbl ? nan_f[1]  : nan_f[0];
        snan_sel  = in_dbl ? snan_f[1] : snan_f[0];
        pred      = (rel_sel.lt & accept.lt) | (rel_sel.eq & accept.eq) |
                    (rel_sel.gt & accept.gt) | (rel_sel.un & accept.un);
        invalid   = signaling ? nan_sel : snan_sel;
        mask_next = !pred ? '0 : (in_dbl ? {DW{1'b1}} : SGL_ONES);
    end

    // Done strobe: one pulse per accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) out_done <= 1'b0;
        else        out_done <= in_valid;
    end

    // Mask register: written only by legal operations
    always_ff @(posedge clk) begin
        if (!rst_n)                   out_mask <= '0;
        else if (in_valid && !illegal) out_mask <= mask_next;
    end

    // Per-operation status: illegal flag and invalid cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_illegal   <= 1'b0;
            out_inv_cause <= 1'b0;
        end else if (in_valid) begin
            out_illegal   <= illegal;
            out_inv_cause <= invalid && !illegal;
        end
    end

    // Sticky invalid flag: accumulates until reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_inv_sticky <= 1'b0;
        else if (in_valid && !illegal && invalid)
            out_inv_sticky <= 1'b1;
    end

endmodule

// File: rtl/fpc_checker.sv
// Module: fpc_checker
// Port-level properties of fp_pred_cmp, attached with bind below.
module fpc_checker #(
    parameter int DW = 64,
    parameter int SW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_dbl,
    input logic [5:0]    in_func,
    input logic          out_done,
    input logic [DW-1:0] out_mask,
    input logic          out_inv_cause,
    input logic          out_inv_sticky,
    input logic          out_illegal
);
    localparam logic [DW-1:0] SGL_ONES = {{(DW-SW){1'b0}}, {SW{1'b1}}};

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_done); // R11
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_done); // R11
    AST_IDLE_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_mask)); // R11
    AST_RSV_BIT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_func[5]) |=> out_illegal); // R4
    AST_NEG_RSV_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_func[4] && (in_func[2:0] == 3'd0 || in_func[2:0] >= 3'd4)) |=> out_illegal); // R5
    AST_ILLEGAL_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n) (out_done && out_illegal) |-> $stable(out_mask)); // R6
    AST_ILLEGAL_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) out_illegal |-> !out_inv_cause); // R6
    AST_DBL_MASK_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n) (out_done && !out_illegal && $past(in_dbl)) |-> (out_mask == '0 || out_mask == '1)); // R7
    AST_SGL_MASK_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n) (out_done && !out_illegal && !$past(in_dbl)) |-> (out_mask == '0 || out_mask == SGL_ONES)); // R7
    AST_CAUSE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) out_inv_cause |-> out_inv_sticky); // R10
    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) out_inv_sticky |=> out_inv_sticky); // R10

endmodule

bind fp_pred_cmp fpc_checker #(.DW(DW), .SW(SW)) u_fpc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_dbl         (in_dbl),
    .in_func        (in_func),
    .out_done       (out_done),
    .out_mask       (out_mask),
    .out_inv_cause  (out_inv_cause),
    .out_inv_sticky (out_inv_sticky),
    .out_illegal    (out_illegal)
);

// File: tb/tb_fp_pred_cmp.sv
`timescale 1ns/1ps
// Bench for fp_pred_cmp: directed corner cases plus seeded random operations,
// all checked against a reference model written from the requirements.
module tb_fp_pred_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [5:0]  in_func = '0;
    logic [63:0] in_opa = '0;
    logic [63:0] in_opb = '0;
    logic        out_done;
    logic [63:0] out_mask;
    logic        out_inv_cause;
    logic        out_inv_sticky;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state
    logic [63:0] m_mask = '0;
    logic        m_sticky = 1'b0;

    always #2.5 clk = ~clk;

    fp_pred_cmp dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_func(in_func), .in_opa(in_opa), .in_opb(in_opb),
        .out_done(out_done), .out_mask(out_mask), .out_inv_cause(out_inv_cause),
        .out_inv_sticky(out_inv_sticky), .out_illegal(out_illegal)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Relation of the pair as {lt, eq, gt, un} by sign-magnitude reasoning (R8)
    function automatic logic [3:0] ref_rel(bit dbl, logic [63:0] a, logic [63:0] b);
        logic sa, sb, na, nb;
        logic [62:0] ma, mb;
        if (dbl) begin
            sa = a[63]; sb = b[63]; ma = a[62:0]; mb = b[62:0];
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
        end else begin
            sa = a[31]; sb = b[31]; ma = {32'd0, a[30:0]}; mb = {32'd0, b[30:0]};
            na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
            nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        end
        if (na || nb) return 4'b0001;
        if (ma == 0 && mb == 0) return 4'b0100;
        if (sa != sb) return sa ? 4'b1000 : 4'b0010;
        if (ma == mb) return 4'b0100;
        if (sa ? (ma > mb) : (ma < mb)) return 4'b1000;
        return 4'b0010;
    endfunction

    function automatic bit ref_nan(bit dbl, logic [63:0] a, bit only_snan);
        if (dbl)
            return (a[62:52] == 11'h7FF) && (a[51:0] != 0) && (!only_snan || !a[51]);
        return (a[30:23] == 8'hFF) && (a[22:0] != 0) && (!only_snan || !a[22]);
    endfunction

    // Accept set {lt, eq, gt, un} from R2/R3; legal=0 for R4/R5 encodings
    function automatic logic [4:0] ref_accept(logic [5:0] f);
        logic [3:0] acc;
        bit legal;
        legal = !f[5];
        acc = 4'b0000;
        if (!f[4]) begin
            case (f[2:0])
                3'd0: acc = 4'b0000;
                3'd1: acc = 4'b0001;
                3'd2: acc = 4'b0100;
                3'd3: acc = 4'b0101;
                3'd4: acc = 4'b1000;
                3'd5: acc = 4'b1001;
                3'd6: acc = 4'b1100;
                default: acc = 4'b1101;
            endcase
        end else begin
            case (f[2:0])
                3'd1: acc = 4'b1110;
                3'd2: acc = 4'b1011;
                3'd3: acc = 4'b1010;
                default: legal = 1'b0;
            endcase
        end
        return {legal, acc};
    endfunction

    // Drive one operation, then check all outputs in the done cycle
    task automatic run_op(string tag, bit dbl, logic [5:0] f, logic [63:0] a, logic [63:0] b);
        logic [4:0] acc;
        logic [3:0] rel;
        bit pred, inv;
        logic cause;
        @(negedge clk);
        in_valid = 1'b1; in_dbl = dbl; in_func = f; in_opa = a; in_opb = b;
        acc = ref_accept(f);
        rel = ref_rel(dbl, a, b);
        pred = |(acc[3:0] & rel);
        inv = f[3] ? (ref_nan(dbl, a, 1'b0) || ref_nan(dbl, b, 1'b0))
                   : (ref_nan(dbl, a, 1'b1) || ref_nan(dbl, b, 1'b1));
        cause = 1'b0;
        if (acc[4]) begin
            m_mask = !pred ? 64'd0 : (dbl ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF);
            cause = inv;
            if (inv) m_sticky = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R11 done"}, 64'(out_done), 64'd1);
        chk({tag, " R2/R3/R7 mask"}, out_mask, m_mask);
        chk({tag, " R4/R5 illegal"}, 64'(out_illegal), 64'(!acc[4]));
        chk({tag, " R9 cause"}, 64'(out_inv_cause), 64'(cause));
        chk({tag, " R10 sticky"}, 64'(out_inv_sticky), 64'(m_sticky));
    endtask

    // Idle cycle with junk on the inputs: nothing may change (R11)
    task automatic idle_check();
        logic [63:0] mk;
        logic st, il, ca;
        mk = out_mask; st = out_inv_sticky; il = out_illegal; ca = out_inv_cause;
        @(negedge clk);
        in_func = 6'($urandom); in_opa = {$urandom, $urandom}; in_opb = {$urandom, $urandom};
        @(negedge clk);
        chk("R11 idle done", 64'(out_done), 64'd0);
        chk("R11 idle mask", out_mask, mk);
        chk("R11 idle flags", {61'd0, st, il, ca}, {61'd0, out_inv_sticky, out_illegal, out_inv_cause});
    endtask

    function automatic logic [63:0] rnd_op(bit dbl, logic [63:0] other);
        logic [63:0] r;
        r = {$urandom, $urandom};
        case ($urandom % 9)
            0: r = dbl ? 64'h0 : {r[63:32], 32'h0};
            1: r = dbl ? 64'h8000_0000_0000_0000 : {r[63:32], 32'h8000_0000};
            2: r = dbl ? {r[63], 12'hFFF, r[50:0] | 51'h1} : {r[63:32], r[31], 9'h1FF, r[21:0] | 22'h1};
            3: r = dbl ? {r[63], 11'h7FF, 1'b0, r[50:0] | 51'h1} : {r[63:32], r[31], 8'hFF, 1'b0, r[21:0] | 22'h1};
            4: r = dbl ? {r[63], 11'h7FF, 52'h0} : {r[63:32], r[31], 8'hFF, 23'h0};
            5: r = other;
            6: r = other ^ 64'h1;
            default: ;
        endcase
        return r;
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R11 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        chk("R12 reset done", 64'(out_done), 64'd0);
        chk("R12 reset mask", out_mask, 64'd0);
        chk("R12 reset flags", {61'd0, out_inv_cause, out_inv_sticky, out_illegal}, 64'd0);
        rst_n = 1'b1;

        // Directed corner cases
        run_op("R8 +0 eq -0 dbl", 1'b1, 6'd2, 64'h0, 64'h8000_0000_0000_0000);
        run_op("R7 sgl 1<2 garbage upper", 1'b0, 6'd4, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000);
        run_op("R2 dbl -2<-1", 1'b1, 6'd4, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000);
        run_op("R2 code0 never", 1'b1, 6'd0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        run_op("R9 quiet qNaN unordered", 1'b1, 6'd1, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        run_op("R2 code7 NaN", 1'b0, 6'd7, 64'h7FC0_0000, 64'h3F80_0000);
        run_op("R3 neg1 ordered NaN", 1'b1, 6'h11, 64'h7FF8_0000_0000_0000, 64'h0);
        run_op("R3 neg2 ne", 1'b0, 6'h12, 64'h3F80_0000, 64'h4000_0000);
        run_op("R3 neg3 eq false", 1'b0, 6'h13, 64'h4000_0000, 64'h4000_0000);
        run_op("R9 sig qNaN", 1'b1, 6'h09, 64'h7FF8_0000_0000_0000, 64'h0);
        run_op("R1 sig same mask", 1'b0, 6'h0C, 64'h3F80_0000, 64'h4000_0000);
        run_op("R9 quiet sNaN sgl", 1'b0, 6'd2, 64'h7FA0_0000, 64'h7FA0_0000);
        run_op("R4 bit5 illegal", 1'b1, 6'h22, 64'h0, 64'h0);
        run_op("R5 neg0 reserved", 1'b1, 6'h10, 64'h7FF4_0000_0000_0000, 64'h0);
        run_op("R5 neg4 reserved", 1'b0, 6'h14, 64'h0, 64'h0);
        run_op("R5 neg7 reserved", 1'b0, 6'h1F, 64'h0, 64'h0);
        idle_check();

        // Seeded random operations
        for (int i = 0; i < 800; i++) begin
            logic [63:0] a;
            logic [63:0] b;
            logic [5:0] f;
            bit dbl;
            dbl = 1'($urandom);
            a = rnd_op(dbl, {$urandom, $urandom});
            b = rnd_op(dbl, a);
            f = 6'($urandom);
            if ($urandom % 5 != 0) f[5] = 1'b0;
            run_op("R2/R3/R8/R9 random", dbl, f, a, b);
            if (i % 100 == 0) idle_check();
        end

        // Reset mid-run clears the sticky flag and all outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_mask = '0;
        m_sticky = 1'b0;
        chk("R12 re-reset sticky", 64'(out_inv_sticky), 64'd0);
        chk("R12 re-reset mask", out_mask, 64'd0);
        run_op("R10 sticky after reset", 1'b1, 6'd0, 64'h0, 64'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule